// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block arbitrates twelve interrupt requests for a small 8051-style processor core. Peripheral flags are latched into pending bits. Each pending bit is gated by its own enable bit and by a global enable. The controller then picks one winner and presents it to the core as a registered request, a source index and a vector address. The core answers with an acknowledge pulse when it enters the service routine and with a return pulse when it leaves.

Eleven sources can each be set to low or high priority. The power-supply-monitor source, at index 11, has a third level of its own above both. It can preempt a running routine at either configurable level, and nothing preempts it. The controller keeps one in-service flag per level. A request is eligible only when its level is above every level now in service. Among eligible requests the highest level wins, and inside one level the lowest index wins.

Three 8-bit registers hold the configuration. The enable register is at 0xA8 and resets to 0x00. The priority register is at 0xB8 and resets to 0x00. The secondary register is at 0xA9 and resets to 0xA0.

Top module: `intr_nest_ctrl`

## Requirements
- R1: After reset, reads return 0x00 from 0xA8, 0x00 from 0xB8 and 0xA0 from 0xA9, and irq_req is low.
- R2: A write with reg_wr high stores reg_wdata at 0xA8, 0xB8 or 0xA9. reg_rdata shows the register selected by reg_addr one cycle later. Any other address reads 0x00, and writes to it are ignored.
- R3: Bit 7 of 0xA8 is a global enable that gates every source, including index 11. While it is clear, no request is raised. Pending requests are kept, and they are granted once the bit is set.
- R4: Bit i of 0xA8 enables source i for i = 0..6. Bits 3..0 of 0xA9 enable sources 10..7, and bit 7 of 0xA9 enables source 11. A masked source stays pending but is never granted.
- R5: Among pending, enabled requests at the same level, the lowest source index wins.
- R6: Bit i of 0xB8 sets source i to high priority for i = 0..7, and bits 6..4 of 0xA9 do the same for sources 10..8. When high and low requests are pending together, the high one is granted first.
- R7: A high request preempts a low routine in service. A low request never preempts a high routine. A request never preempts a routine of its own level.
- R8: Source 11 is the only source at the top level. It is granted while a high or low routine is in service. No request is granted while a top-level routine is in service.
- R9: While irq_req is high, irq_vec equals 0x0003 + 8 × irq_idx.
- R10: An irq_ack while irq_req is high does three things: it clears the pending bit of the presented source, it marks that source's level in service, and it drops irq_req in the following cycle.
- R11: An irq_reti pulse clears only the highest in-service level. Lower levels stay in service.
- R12: A flag sampled at one clock edge raises irq_req at the next edge, not at the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| src_flag | input | 12 | Request flags from the sources, one bit per index |
| irq_ack | input | 1 | Core enters the presented routine |
| irq_reti | input | 1 | Core returns from a routine |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Index of the presented source |
| irq_vec | output | 16 | Vector address of the presented source |

## Verification
A wrong in-service flag shows up at the ports in one of two ways. Either a request is held back after a return that should have released it, or a request preempts where it should wait. Both appear at irq_req two edges after the ack or reti that corrupted the state. A pending bit that was lost or never cleared appears as a missing grant or a repeated grant within two cycles of the next ack. A wrong enable or priority mapping shows as the wrong irq_idx and irq_vec on the first grant after a simultaneous burst of flags.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NLVL = 3;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_LOW  = 2'd0;
  localparam lvl_t LVL_HIGH = 2'd1;
  localparam lvl_t LVL_TOP  = 2'd2;
endpackage

// File: rtl/intr_regs.sv
module intr_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NSRC = 12,
  parameter logic [AW-1:0] ADDR_ENA = 8'hA8,
  parameter logic [AW-1:0] ADDR_PRI = 8'hB8,
  parameter logic [AW-1:0] ADDR_SEC = 8'hA9,
  parameter logic [DW-1:0] SEC_RST  = 8'hA0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            glob_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_hi
);
  localparam int ENA_CNT = 7;        // sources enabled by the primary register
  localparam int PRI_CNT = 8;        // sources prioritised by the priority register
  localparam int SEC_EN_CNT = 4;     // sources enabled by the secondary register
  localparam int TOP_IDX = NSRC - 1; // fixed top-level source

  logic [DW-1:0] ena_q, pri_q, sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
      pri_q <= '0;
      sec_q <= SEC_RST;
    end else if (wr) begin
      if (addr == ADDR_ENA) ena_q <= wdata;
      if (addr == ADDR_PRI) pri_q <= wdata;
      if (addr == ADDR_SEC) sec_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (addr == ADDR_ENA) rdata <= ena_q;
    else if (addr == ADDR_PRI) rdata <= pri_q;
    else if (addr == ADDR_SEC) rdata <= sec_q;
    else rdata <= '0;
  end

  assign glob_en = ena_q[DW-1];

  always_comb begin
    src_en = '0;
    src_hi = '0;
    for (int i = 0; i < ENA_CNT; i++) src_en[i] = ena_q[i];
    for (int i = 0; i < SEC_EN_CNT; i++) src_en[ENA_CNT+i] = sec_q[i];
    src_en[TOP_IDX] = sec_q[DW-1];
    for (int i = 0; i < PRI_CNT; i++) src_hi[i] = pri_q[i];
    for (int i = PRI_CNT; i < TOP_IDX; i++) src_hi[i] = sec_q[i-PRI_CNT+SEC_EN_CNT];
  end
endmodule

// File: rtl/intr_pending.sv
module intr_pending #(
  parameter int NSRC = 12,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] flag,
  input  logic            clr_en,
  input  logic [IW-1:0]   clr_idx,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (clr_en && clr_idx == IW'(i)) clr_vec[i] = 1'b1;
  end

  // a new flag in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | flag;
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int NSRC = 12,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            glob_en,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic [NLVL-1:0] ins,
  output logic            win_valid,
  output logic [IW-1:0]   win_idx,
  output lvl_t            win_lvl
);
  lvl_t            src_lvl [NSRC];
  logic [NSRC-1:0] elig;
  logic [NLVL-1:0] any_lvl;
  logic [IW-1:0]   first_idx [NLVL];

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    if (i == NSRC - 1) begin : g_top
      assign src_lvl[i] = LVL_TOP;
    end else begin : g_cfg
      assign src_lvl[i] = src_hi[i] ? LVL_HIGH : LVL_LOW;
    end
  end

  assign elig = pend & src_en & {NSRC{glob_en}};

  always_comb begin
    any_lvl = '0;
    for (int l = 0; l < NLVL; l++) first_idx[l] = '0;
    // descending scan: lowest index of each level is written last
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any_lvl[src_lvl[i]]   = 1'b1;
        first_idx[src_lvl[i]] = IW'(i);
      end
    end
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LVL_LOW;
    for (int l = 0; l < NLVL; l++) begin
      if (any_lvl[l] && ((ins >> l) == '0)) begin
        win_valid = 1'b1;
        win_idx   = first_idx[l];
        win_lvl   = lvl_t'(l);
      end
    end
  end
endmodule

// File: rtl/intr_nest_ctrl.sv
module intr_nest_ctrl
  import intr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NSRC = 12,
  parameter int VW = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] src_flag,
  input  logic            irq_ack,
  input  logic            irq_reti,
  output logic            irq_req,
  output logic [IW-1:0]   irq_idx,
  output logic [VW-1:0]   irq_vec
);
  logic            glob_en;
  logic [NSRC-1:0] src_en, src_hi, pend;
  logic [NLVL-1:0] ins_q, ins_set, ins_clr;
  logic            win_valid, take;
  logic [IW-1:0]   win_idx;
  lvl_t            win_lvl, lvl_q;

  assign take = irq_req && irq_ack;

  intr_regs #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .glob_en(glob_en), .src_en(src_en), .src_hi(src_hi)
  );

  intr_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .flag(src_flag), .clr_en(take), .clr_idx(irq_idx),
    .pend(pend)
  );

  intr_arbiter #(.NSRC(NSRC)) u_arb (
    .glob_en(glob_en), .pend(pend), .src_en(src_en), .src_hi(src_hi),
    .ins(ins_q), .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_comb begin
    ins_set = '0;
    ins_clr = '0;
    if (take) ins_set[lvl_q] = 1'b1;
    if (irq_reti)
      for (int l = 0; l < NLVL; l++)
        if (ins_q[l]) ins_clr = NLVL'(1) << l;
  end

  always_ff @(posedge clk) begin
    if (rst) ins_q <= '0;
    else     ins_q <= (ins_q & ~ins_clr) | ins_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_idx <= '0;
      lvl_q   <= LVL_LOW;
      irq_vec <= '0;
    end else begin
      irq_req <= take ? 1'b0 : win_valid;
      irq_idx <= win_idx;
      lvl_q   <= win_lvl;
      irq_vec <= VW'(VEC_BASE) + VW'(VEC_STEP) * VW'(win_idx);
    end
  end
endmodule

// File: rtl/intr_nest_chk.sv
module intr_nest_chk
  import intr_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int VW = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_ack,
  input logic            irq_reti,
  input logic            irq_req,
  input logic [IW-1:0]   irq_idx,
  input logic [VW-1:0]   irq_vec,
  input logic            glob_en,
  input logic [NLVL-1:0] ins_q,
  input lvl_t            lvl_q
);
  AST_VEC_OF_IDX: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_vec == VW'(VEC_BASE) + VW'(VEC_STEP) * VW'(irq_idx)); // R9

  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> !irq_req); // R10

  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> ins_q[$past(lvl_q)]); // R10

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && $past(!glob_en)) |-> !irq_req); // R3

  AST_RETI_ONE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_reti && !(irq_req && irq_ack) && ins_q != '0) |=>
      $countones(ins_q) == $countones($past(ins_q)) - 1); // R11

  AST_TOP_IS_MONITOR: assert property (@(posedge clk) disable iff (rst)
    (irq_req && lvl_q == LVL_TOP) |-> irq_idx == IW'(NSRC - 1)); // R8
endmodule

bind intr_nest_ctrl intr_nest_chk u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_reti(irq_reti),
  .irq_req(irq_req), .irq_idx(irq_idx), .irq_vec(irq_vec),
  .glob_en(glob_en), .ins_q(ins_q), .lvl_q(lvl_q)
);

// File: tb/intr_nest_ctrl_test.sv
`timescale 1ns/1ps
module intr_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [11:0] src_flag = '0;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_idx;
  logic [15:0] irq_vec;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intr_nest_ctrl uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_flag(src_flag),
    .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
    .irq_idx(irq_idx), .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    tick();
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [11:0] m);
    src_flag = m;
    tick();
    src_flag = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R10 req drops after ack", irq_req, 0);
  endtask

  task automatic reti();
    irq_reti = 1'b1;
    tick();
    irq_reti = 1'b0;
  endtask

  task automatic chk_grant(input int idx, input string tag);
    chk(irq_req == 1'b1, {tag, " req"}, irq_req, 1);
    chk(irq_idx == 4'(idx), {tag, " idx"}, irq_idx, idx);
    chk(irq_vec == 16'(3 + 8 * idx), {tag, " R9 vec"}, irq_vec, 3 + 8 * idx);
  endtask

  task automatic chk_none(input string tag);
    chk(irq_req == 1'b0, {tag, " no req"}, irq_req, 0);
  endtask

  task automatic t_reset();
    chk_none("R1");
    rd_chk(8'hA8, 8'h00, "R1 enable reset");
    rd_chk(8'hB8, 8'h00, "R1 priority reset");
    rd_chk(8'hA9, 8'hA0, "R1 secondary reset");
  endtask

  task automatic t_regs();
    wr(8'hA8, 8'h55); rd_chk(8'hA8, 8'h55, "R2 enable rw");
    wr(8'hB8, 8'hAA); rd_chk(8'hB8, 8'hAA, "R2 priority rw");
    wr(8'hA9, 8'h3C); rd_chk(8'hA9, 8'h3C, "R2 secondary rw");
    wr(8'h10, 8'hFF); rd_chk(8'h10, 8'h00, "R2 unmapped read");
    rd_chk(8'hA8, 8'h55, "R2 unmapped write ignored");
    wr(8'hA8, 8'h00); wr(8'hB8, 8'h00); wr(8'hA9, 8'h8F);
  endtask

  task automatic t_global();
    wr(8'hA8, 8'h01);
    pulse(12'h001);
    tick(); tick();
    chk_none("R3 global off");
    wr(8'hA8, 8'h81);
    tick();
    chk_grant(0, "R3 granted after global on");
    ack(); reti(); tick();
    chk_none("R3 cleared");
  endtask

  task automatic t_mask();
    wr(8'hA8, 8'h88);
    pulse(12'h00A);
    tick();
    chk_grant(3, "R4 enabled source only");
    ack(); reti(); tick(); tick();
    chk_none("R4 masked stays silent");
    wr(8'hA8, 8'h8A);
    tick();
    chk_grant(1, "R4 masked source kept pending");
    ack(); reti();
  endtask

  task automatic t_poll();
    wr(8'hA8, 8'hFF); wr(8'hB8, 8'h00); wr(8'hA9, 8'h8F);
    pulse(12'h224);
    chk_none("R12 not at sampling edge");
    tick();
    chk_grant(2, "R5 lowest index first");
    ack(); reti(); tick();
    chk_grant(5, "R5 second in order");
    ack(); reti(); tick();
    chk_grant(9, "R5 last in order");
    ack(); reti();
  endtask

  task automatic t_prio();
    wr(8'hB8, 8'h10);
    pulse(12'h011);
    tick();
    chk_grant(4, "R6 high before low");
    ack(); tick(); tick();
    chk_none("R7 low waits for high");
    reti(); tick();
    chk_grant(0, "R6 low after high");
    ack(); reti();
  endtask

  task automatic t_nest();
    pulse(12'h001); tick();
    chk_grant(0, "R7 low grant");
    ack();
    pulse(12'h002); tick(); tick();
    chk_none("R7 same level no preempt");
    pulse(12'h010); tick();
    chk_grant(4, "R7 high preempts low");
    ack(); reti(); tick();
    chk_none("R11 low level still in service");
    reti(); tick();
    chk_grant(1, "R11 low released");
    ack(); reti();
  endtask

  task automatic t_top();
    wr(8'hA8, 8'h7F);
    pulse(12'h800); tick();
    chk_none("R3 gates monitor source");
    wr(8'hA8, 8'hFF); tick();
    chk_grant(11, "R8 monitor grant");
    ack();
    pulse(12'h010); tick(); tick();
    chk_none("R8 nothing preempts top");
    reti(); tick();
    chk_grant(4, "R8 high after top");
    ack();
    pulse(12'h800); tick();
    chk_grant(11, "R8 top preempts high");
    ack(); reti(); reti(); tick();
    chk_none("R11 all returned");
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_regs();
    t_global();
    t_mask();
    t_poll();
    t_prio();
    t_nest();
    t_top();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule